// File: doc/BRIEF.md
# OQPSK DSSS Baseband Modulator

This block turns a stream of bytes into spread offset-QPSK baseband samples for a low-rate 2.4 GHz personal-area radio. Each byte becomes two 4-bit symbols, low nibble first. Each symbol picks one of sixteen 32-chip pseudo-noise codes. The chips alternate between the I and Q branches, and the Q branch lags I by one chip period. Every branch chip is drawn as a half-sine pulse. The block emits signed 6-bit sample pairs for two DACs at a rate set by a clock-enable divider.

A frame opens on a start strobe. Bytes then enter through a valid/ready handshake, and the byte flagged as last closes the frame. When no byte is waiting at a symbol boundary, the I branch falls to zero at once. The Q branch finishes its last half-pulse and then also falls to zero. Both stay at zero until more data arrives.

Top module: `oqpsk_dsss_mod`

## Requirements
- R1: `sample_en_o` is a one-cycle pulse that repeats every DIV clocks. The default is DIV = 2. The sample outputs change only on the clock edge just before each pulse.
- R2: After reset, `ready_o`, `i_o` and `q_o` are zero. Before a start strobe, a byte offered with `valid_i` is not taken, and both outputs stay zero.
- R3: `ready_o` is high only while a frame is open and no byte is buffered. After a byte is accepted, `ready_o` goes low. It stays low until that byte's high nibble begins shaping, about 128 sample periods later. A byte with `last_i` set closes the frame, and `ready_o` then stays low. A start strobe while a frame is open has no effect.
- R4: The low nibble of each byte is spread first, then the high nibble.
- R5: The chip codes are defined as follows. For symbol 0, chip c is bit c of 32'h744AC39B. For symbol k in 0..7, chip c equals chip (c - 4k) mod 32 of symbol 0. Symbol k+8 is symbol k with every odd-indexed chip inverted.
- R6: Chip 2j of a symbol drives the I branch and chip 2j+1 drives the Q branch. A chip value of 1 gives a positive pulse and a value of 0 gives a negative pulse.
- R7: Each branch chip lasts 8 samples. The magnitudes are round(31·sin(π(p+0.5)/8)) for p = 0..7, which gives 6, 17, 26, 30, 30, 26, 17, 6. One symbol occupies 128 samples.
- R8: The Q samples follow the I samples by exactly 4 sample periods. After the I branch of the last symbol ends, Q still emits its final 4 samples.
- R9: When bytes arrive in time, consecutive symbols follow each other with no gap samples.
- R10: On underflow inside a frame, both outputs are zero after the Q tail. They stay zero until a new byte arrives. A new byte restarts I at once, and Q joins it 4 samples later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Frame open strobe |
| data_i | input | 8 | Byte to spread |
| valid_i | input | 1 | Byte is offered |
| last_i | input | 1 | Offered byte is the last of the frame |
| ready_o | output | 1 | Byte will be accepted this cycle if valid |
| sample_en_o | output | 1 | New sample pair is present on i_o/q_o |
| i_o | output | 6 | In-phase sample, two's complement |
| q_o | output | 6 | Quadrature sample, two's complement |

## Verification
The hardest state to reach is underflow in the middle of a frame. To produce it, the bench supplies one byte that is not marked last and then waits for many symbol periods before sending the next byte. It checks several things: that Q's trailing half-pulse outlives I, that the gap is entirely zero, that `ready_o` stays high while the frame is open, and that the resumed symbols restart with Q lagging by exactly 4 samples. The sixteen codes are covered in one continuous frame, and the bench finds the start of each waveform from its first nonzero I sample, so start-up latency does not affect the comparison.

// File: rtl/oqpsk_pkg.sv
package oqpsk_pkg;
  localparam int CHIPS   = 32;
  localparam int SPC     = 4;             // samples per chip period
  localparam int SPS     = CHIPS * SPC;   // samples per symbol
  localparam int DAC_W   = 6;
  localparam int CNT_W   = $clog2(SPS);

  // code for symbol: rotate base by 4 chips per step, odd chips flipped for upper half
  function automatic logic [CHIPS-1:0] chip_seq(input logic [CHIPS-1:0] base,
                                                input logic [3:0] sym);
    logic [CHIPS-1:0] r;
    r = base;
    for (int k = 0; k < 7; k++)
      if (k < int'(sym[2:0])) r = {r[CHIPS-5:0], r[CHIPS-1:CHIPS-4]};
    if (sym[3]) r = r ^ {(CHIPS/2){2'b10}};
    return r;
  endfunction

  // quarter of a half-sine, amplitude 31, midpoint-sampled
  function automatic logic [DAC_W-2:0] qw_mag(input logic [1:0] idx);
    case (idx)
      2'd0:    return 5'd6;
      2'd1:    return 5'd17;
      2'd2:    return 5'd26;
      default: return 5'd30;
    endcase
  endfunction
endpackage

// File: rtl/oqpsk_rate_gen.sv
module oqpsk_rate_gen #(
  parameter int DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic se_o
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (cnt_q == W'(DIV - 1))  cnt_q <= '0;
    else                            cnt_q <= cnt_q + 1'b1;
  end

  assign se_o = (cnt_q == W'(DIV - 1));

  generate
    if (DIV > 1) begin : g_gap
      p_strobe_gap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        se_o |=> !se_o);
    end
  endgenerate
endmodule

// File: rtl/oqpsk_symbol_feed.sv
module oqpsk_symbol_feed
  import oqpsk_pkg::*;
#(
  parameter logic [CHIPS-1:0] CHIP_BASE = 32'h744A_C39B
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             se_i,
  input  logic             start_i,
  input  logic [7:0]       byte_i,
  input  logic             valid_i,
  input  logic             last_i,
  output logic             ready_o,
  output logic             sym_act_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CHIPS-1:0] chips_o
);
  logic             frame_q, held_q, hi_q, last_q, sym_act_q;
  logic [7:0]       byte_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CHIPS-1:0] chips_q;
  logic             acc, bnd;

  assign ready_o = frame_q && !held_q;
  assign acc     = valid_i && ready_o;
  assign bnd     = se_i && (!sym_act_q || cnt_q == CNT_W'(SPS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q   <= 1'b0;
      held_q    <= 1'b0;
      hi_q      <= 1'b0;
      last_q    <= 1'b0;
      sym_act_q <= 1'b0;
      byte_q    <= '0;
      cnt_q     <= '0;
      chips_q   <= '0;
    end else begin
      if (start_i && !frame_q) frame_q <= 1'b1;
      if (acc) begin
        byte_q <= byte_i;
        held_q <= 1'b1;
        last_q <= last_i;
        hi_q   <= 1'b0;
      end
      if (se_i && sym_act_q) cnt_q <= cnt_q + 1'b1;
      if (bnd) begin
        cnt_q <= '0;
        if (held_q) begin
          sym_act_q <= 1'b1;
          chips_q   <= chip_seq(CHIP_BASE, hi_q ? byte_q[7:4] : byte_q[3:0]);
          hi_q      <= ~hi_q;
          if (hi_q) begin
            held_q <= 1'b0;
            if (last_q) frame_q <= 1'b0;
          end
        end else begin
          sym_act_q <= 1'b0;
        end
      end
    end
  end

  assign sym_act_o = sym_act_q;
  assign cnt_o     = cnt_q;
  assign chips_o   = chips_q;

  p_accept_blocks_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> !ready_o);
  p_no_gap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bnd && held_q) |=> (sym_act_q && cnt_q == '0));
  p_closed_no_ready_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!frame_q && !start_i) |=> !ready_o);
endmodule

// File: rtl/oqpsk_pulse_shaper.sv
module oqpsk_pulse_shaper
  import oqpsk_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    se_i,
  input  logic                    sym_act_i,
  input  logic [CNT_W-1:0]        cnt_i,
  input  logic [CHIPS-1:0]        chips_i,
  output logic                    strobe_o,
  output logic signed [DAC_W-1:0] i_o,
  output logic signed [DAC_W-1:0] q_o
);
  logic [CNT_W-4:0]        pair;
  logic [2:0]              ph;
  logic                    ci, cq;
  logic [DAC_W-2:0]        mag;
  logic signed [DAC_W-1:0] pos, i_pre, q_pre, i_q;
  logic signed [DAC_W-1:0] qd [SPC+1];
  logic                    strobe_q;

  assign pair  = cnt_i[CNT_W-1:3];
  assign ph    = cnt_i[2:0];
  assign ci    = chips_i[{pair, 1'b0}];
  assign cq    = chips_i[{pair, 1'b1}];
  assign mag   = qw_mag(ph[2] ? ~ph[1:0] : ph[1:0]);
  assign pos   = {1'b0, mag};
  assign i_pre = !sym_act_i ? '0 : (ci ? pos : -pos);
  assign q_pre = !sym_act_i ? '0 : (cq ? pos : -pos);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      i_q      <= '0;
      qd[0]    <= '0;
      strobe_q <= 1'b0;
    end else begin
      strobe_q <= se_i;
      if (se_i) begin
        i_q   <= i_pre;
        qd[0] <= q_pre;
      end
    end
  end

  // Q lags I by one chip period: SPC extra sample stages
  generate
    for (genvar k = 1; k <= SPC; k++) begin : g_qdly
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   qd[k] <= '0;
        else if (se_i) qd[k] <= qd[k-1];
      end
    end
  endgenerate

  assign strobe_o = strobe_q;
  assign i_o      = i_q;
  assign q_o      = qd[SPC];

  p_idle_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (se_i && !sym_act_i) |=> (i_o == '0));
  p_active_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (se_i && sym_act_i) |=> (i_o != '0));
  p_hold_between_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !se_i |=> ($stable(i_o) && $stable(q_o)));
  p_strobe_follows_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |-> $past(se_i));
endmodule

// File: rtl/oqpsk_dsss_mod.sv
module oqpsk_dsss_mod
  import oqpsk_pkg::*;
#(
  parameter int               DIV       = 2,
  parameter logic [CHIPS-1:0] CHIP_BASE = 32'h744A_C39B
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [7:0] data_i,
  input  logic       valid_i,
  input  logic       last_i,
  output logic       ready_o,
  output logic       sample_en_o,
  output logic [5:0] i_o,
  output logic [5:0] q_o
);
  logic             se, sym_act;
  logic [CNT_W-1:0] cnt;
  logic [CHIPS-1:0] chips;
  logic signed [DAC_W-1:0] i_s, q_s;

  oqpsk_rate_gen #(.DIV(DIV)) i_rate (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .se_o  (se)
  );

  oqpsk_symbol_feed #(.CHIP_BASE(CHIP_BASE)) i_feed (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .se_i     (se),
    .start_i  (start_i),
    .byte_i   (data_i),
    .valid_i  (valid_i),
    .last_i   (last_i),
    .ready_o  (ready_o),
    .sym_act_o(sym_act),
    .cnt_o    (cnt),
    .chips_o  (chips)
  );

  oqpsk_pulse_shaper i_shaper (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .se_i     (se),
    .sym_act_i(sym_act),
    .cnt_i    (cnt),
    .chips_i  (chips),
    .strobe_o (sample_en_o),
    .i_o      (i_s),
    .q_o      (q_s)
  );

  assign i_o = i_s;
  assign q_o = q_s;
endmodule

// File: tb/test_oqpsk_dsss_mod.sv
`timescale 1ns/1ps
module test_oqpsk_dsss_mod;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0, valid = 1'b0, last = 1'b0;
  logic [7:0] data = '0;
  logic       ready, sen;
  logic [5:0] i_w, q_w;

  int vectors = 0, errors = 0;
  bit done = 1'b0;

  logic signed [5:0] cap_i [0:8191];
  logic signed [5:0] cap_q [0:8191];
  int  ncap = 0;
  bit  cap_on = 1'b0;
  bit  ready_seen = 1'b0;
  int  seg_sym [0:15];

  always #4 clk = ~clk;

  oqpsk_dsss_mod i_oqpsk_dsss_mod (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .data_i(data),
    .valid_i(valid), .last_i(last), .ready_o(ready), .sample_en_o(sen),
    .i_o(i_w), .q_o(q_w)
  );

  always @(negedge clk) begin
    if (cap_on && sen && ncap < 8192) begin
      cap_i[ncap] = $signed(i_w);
      cap_q[ncap] = $signed(q_w);
      ncap++;
    end
    if (cap_on && ready) ready_seen = 1'b1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int mag(input int p);
    real pi = 3.14159265358979;
    return $rtoi($floor(31.0 * $sin(pi * (p + 0.5) / 8.0) + 0.5));
  endfunction

  function automatic int chip(input int sym, input int c);
    logic [31:0] base = 32'h744AC39B;
    int b = base[(c - 4 * (sym % 8) + 64) % 32];
    if (sym >= 8 && (c % 2) == 1) b = 1 - b;
    return b;
  endfunction

  function automatic int exp_branch(input int sym, input int s, input int odd);
    int j = s / 8;
    int m = mag(s % 8);
    return (chip(sym, 2 * j + odd) == 1) ? m : -m;
  endfunction

  function automatic int find_nz(input int from);
    for (int k = from; k < ncap; k++) if (cap_i[k] != 0) return k;
    return -1;
  endfunction

  task automatic check_seg(input int st, input int ns, input string req);
    for (int n = 0; n < 128 * ns + 4; n++) begin
      int ei = (n < 128 * ns) ? exp_branch(seg_sym[n / 128], n % 128, 0) : 0;
      int m  = n - 4;
      int eq = (m < 0) ? 0 : exp_branch(seg_sym[m / 128], m % 128, 1);
      chk(cap_i[st + n] == ei, {req, " I"}, cap_i[st + n], ei);
      chk(cap_q[st + n] == eq, {req, " Q"}, cap_q[st + n], eq);
    end
  endtask

  task automatic check_zero(input int from, input int to, input string req);
    for (int k = from; k < to; k++) begin
      chk(cap_i[k] == 0, {req, " I zero"}, cap_i[k], 0);
      chk(cap_q[k] == 0, {req, " Q zero"}, cap_q[k], 0);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input bit l);
    data = b; last = l; valid = 1'b1;
    while (1) begin
      if (ready) begin
        @(negedge clk);
        break;
      end
      @(negedge clk);
    end
    valid = 1'b0; last = 1'b0;
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int st, cnt, gap_end, s1;
    repeat (5) @(negedge clk);
    // R2: reset values
    chk(ready == 1'b0, "R2 ready after reset", ready, 0);
    chk(i_w == 6'd0, "R2 i after reset", i_w, 0);
    chk(q_w == 6'd0, "R2 q after reset", q_w, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: strobe every DIV=2 clocks, never back to back
    cnt = 0;
    for (int k = 0; k < 40; k++) begin
      bit prev = sen;
      @(negedge clk);
      if (sen) cnt++;
      chk(!(prev && sen), "R1 strobe spacing", sen, 0);
    end
    chk(cnt == 20, "R1 strobe count", cnt, 20);

    // R2: byte offered before any start is ignored
    ncap = 0; cap_on = 1'b1; ready_seen = 1'b0;
    data = 8'h55; valid = 1'b1;
    repeat (600) @(negedge clk);
    valid = 1'b0;
    cap_on = 1'b0;
    chk(ready_seen == 1'b0, "R2 ready while idle", ready_seen, 0);
    check_zero(0, ncap, "R2 idle");

    // Frame A: all sixteen codes in order, back to back (R4 R5 R6 R7 R8 R9)
    ncap = 0; cap_on = 1'b1;
    pulse_start();
    for (int b = 0; b < 8; b++) begin
      send_byte({4'(2 * b + 1), 4'(2 * b)}, b == 7);
      if (b == 3) pulse_start();   // R3: start while open has no effect
    end
    repeat (800) @(negedge clk);
    cap_on = 1'b0;
    chk(ready == 1'b0, "R3 frame closed by last", ready, 0);
    st = find_nz(0);
    chk(st >= 0, "R9 waveform found", st, 0);
    if (st >= 0) begin
      check_zero(0, st, "R2 before frame");
      for (int k = 0; k < 16; k++) seg_sym[k] = k;
      check_seg(st, 16, "R5 R6 R7 R8 R9 codes 0-15");
      check_zero(st + 16 * 128 + 4, st + 16 * 128 + 24, "R8 after tail");
    end

    // Frame B: underflow mid-frame (R3 R10)
    ncap = 0; cap_on = 1'b1;
    pulse_start();
    send_byte(8'h21, 1'b0);
    chk(ready == 1'b0, "R3 ready low after accept", ready, 0);
    cnt = 0;
    while (!ready && cnt < 400) begin
      @(negedge clk);
      cnt++;
    end
    chk(cnt >= 256 && cnt <= 260, "R3 release at high nibble", cnt, 257);
    repeat (1500) @(negedge clk);
    chk(ready == 1'b1, "R3 frame open during underflow", ready, 1);
    send_byte(8'h43, 1'b1);
    repeat (800) @(negedge clk);
    cap_on = 1'b0;
    st = find_nz(0);
    chk(st >= 0, "R10 first segment found", st, 0);
    if (st >= 0) begin
      seg_sym[0] = 1; seg_sym[1] = 2;
      check_seg(st, 2, "R4 R10 segment 1");
      gap_end = st + 260;
      s1 = find_nz(gap_end);
      chk(s1 > gap_end, "R10 gap present", s1, gap_end + 1);
      if (s1 > gap_end) begin
        check_zero(gap_end, s1, "R10 gap");
        seg_sym[0] = 3; seg_sym[1] = 4;
        check_seg(s1, 2, "R10 resume");
      end
    end

    // Frame C: mixed patterns
    ncap = 0; cap_on = 1'b1;
    pulse_start();
    send_byte(8'hA5, 1'b0);
    send_byte(8'h3C, 1'b0);
    send_byte(8'hFF, 1'b0);
    send_byte(8'h00, 1'b1);
    repeat (800) @(negedge clk);
    cap_on = 1'b0;
    st = find_nz(0);
    chk(st >= 0, "R4 mixed found", st, 0);
    if (st >= 0) begin
      seg_sym[0] = 5;  seg_sym[1] = 10; seg_sym[2] = 12; seg_sym[3] = 3;
      seg_sym[4] = 15; seg_sym[5] = 15; seg_sym[6] = 0;  seg_sym[7] = 0;
      check_seg(st, 8, "R4 R9 mixed bytes");
    end

    finish_run();
  end
endmodule